// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block is a small fully associative cache of page translations for a paged memory unit. A request presents a 16-bit virtual address, the identifier of the running process and a load/store flag. All entries are compared in parallel on page number and process identifier. The outcome is registered and reported one cycle later as a hit with the physical address, a miss, or a protection fault.

Because each entry is tagged with its owning process, translations of several processes can coexist and a context switch needs no flush. When the page table has been walked after a miss, the translation is installed through a refill port. A flush input empties the whole cache. The page table walk and replacement policy beyond the built-in slot choice are left to the surrounding logic.

Top module: `tagged_xlate_cache`

## Requirements
- R1: The virtual address splits into page number bits [15:10] and offset bits [9:0]. On a hit the 18-bit physical address is {frame[7:0], offset[9:0]}, with the offset passed through unchanged.
- R2: A request hits when an entry is valid and both its page number and its process identifier equal the request's. rsp_valid_o is high exactly in the cycle after req_valid_i was sampled high.
- R3: When no entry matches, the response has rsp_miss_o=1, and rsp_paddr_o, rsp_dirty_o and rsp_wp_o are 0.
- R4: When rsp_valid_o is high, exactly one of hit, miss and fault is high. When rsp_valid_o is low, all three are low.
- R5: A store that matches a write-protected entry gives rsp_fault_o=1, rsp_paddr_o=0 and rsp_wp_o=1, and leaves the entry's dirty bit unchanged. A load to the same entry hits normally.
- R6: A store hit on an entry that is not write-protected sets that entry's dirty bit. rsp_dirty_o shows the updated bit on that response and on every later hit to the entry. On a load hit, rsp_dirty_o shows the stored bit.
- R7: A refill whose page number and process identifier match a valid entry overwrites that entry in place. Otherwise the refill goes to the lowest-index invalid entry.
- R8: When every entry is valid and nothing matches, a refill replaces the entry at a round-robin pointer. The pointer is 0 after reset and after a flush, and it advances by one (wrapping at 8) on each such replacement.
- R9: A flush invalidates all entries and resets the pointer. A refill in the same cycle is discarded. A lookup in the same cycle still sees the contents from before the flush.
- R10: A lookup in the same cycle as a refill sees the contents from before the refill. A lookup and a store-hit dirty update in the same cycle as a refill to that entry lose to the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 16 | Virtual address |
| req_pid_i | input | 4 | Current process identifier |
| req_store_i | input | 1 | 1 = store, 0 = load |
| flush_i | input | 1 | Invalidate all entries |
| fill_valid_i | input | 1 | Refill strobe |
| fill_vpn_i | input | 6 | Refill page number |
| fill_pid_i | input | 4 | Refill process identifier |
| fill_pfn_i | input | 8 | Refill frame number |
| fill_wp_i | input | 1 | Refill write-protect bit |
| fill_dirty_i | input | 1 | Refill dirty bit |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Store to write-protected page |
| rsp_paddr_o | output | 18 | Physical address |
| rsp_dirty_o | output | 1 | Matched entry's dirty bit |
| rsp_wp_o | output | 1 | Matched entry's write-protect bit |

## Verification
Directed cases walk through several distinct situations:
- an empty cache;
- the same page under two processes, which separates the process-tag comparison from the page comparison;
- an in-place refill against a refill into a new slot;
- load against store on a protected page;
- a full cache, which exposes the round-robin order;
- same-cycle flush, refill and lookup, which shows what a lookup sees when state changes in that cycle.

A long random phase then mixes refills, loads, stores and rare flushes over a small page and process range. This forces frequent matches, overwrites and evictions. Every response is compared against a behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VPN_W = 6;
  parameter int OFF_W = 10;
  parameter int PFN_W = 8;
  parameter int PID_W = 4;
  localparam int VA_W = VPN_W + OFF_W;
  localparam int PA_W = PFN_W + OFF_W;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [PFN_W-1:0] pfn;
    logic             wp;
    logic             dirty;
  } entry_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N = 8
) (
  input  tlb_pkg::entry_t [N-1:0]    ent_i,
  input  logic [tlb_pkg::VPN_W-1:0]  vpn_i,
  input  logic [tlb_pkg::PID_W-1:0]  pid_i,
  output logic [N-1:0]               match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = ent_i[g].valid && (ent_i[g].vpn == vpn_i) && (ent_i[g].pid == pid_i);
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     match_i,
  input  logic [N-1:0]     valid_i,
  input  logic [IDX_W-1:0] rr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             use_rr_o
);
  logic             m_any, i_any;
  logic [IDX_W-1:0] m_idx, i_idx;

  tlb_prio #(.N(N), .IDX_W(IDX_W)) u_match (.vec_i(match_i),  .any_o(m_any), .idx_o(m_idx));
  tlb_prio #(.N(N), .IDX_W(IDX_W)) u_free  (.vec_i(~valid_i), .any_o(i_any), .idx_o(i_idx));

  // in-place overwrite first, then free slot, then round robin
  assign idx_o    = m_any ? m_idx : (i_any ? i_idx : rr_i);
  assign use_rr_o = !m_any && !i_any;
endmodule

// File: rtl/tagged_xlate_cache.sv
module tagged_xlate_cache #(
  parameter int NUM_ENT = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [tlb_pkg::VA_W-1:0]  req_vaddr_i,
  input  logic [tlb_pkg::PID_W-1:0] req_pid_i,
  input  logic                      req_store_i,
  input  logic                      flush_i,
  input  logic                      fill_valid_i,
  input  logic [tlb_pkg::VPN_W-1:0] fill_vpn_i,
  input  logic [tlb_pkg::PID_W-1:0] fill_pid_i,
  input  logic [tlb_pkg::PFN_W-1:0] fill_pfn_i,
  input  logic                      fill_wp_i,
  input  logic                      fill_dirty_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_hit_o,
  output logic                      rsp_miss_o,
  output logic                      rsp_fault_o,
  output logic [tlb_pkg::PA_W-1:0]  rsp_paddr_o,
  output logic                      rsp_dirty_o,
  output logic                      rsp_wp_o
);
  import tlb_pkg::*;
  localparam int IDX_W = $clog2(NUM_ENT);

  entry_t [NUM_ENT-1:0] ent_q, ent_d;
  logic   [IDX_W-1:0]   rr_q, rr_d;
  logic   [NUM_ENT-1:0] valid_vec;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_vld
    assign valid_vec[g] = ent_q[g].valid;
  end

  // lookup path
  logic [VPN_W-1:0]   req_vpn;
  logic [OFF_W-1:0]   req_off;
  logic [NUM_ENT-1:0] l_match;
  logic               l_any;
  logic [IDX_W-1:0]   l_idx;
  entry_t             l_ent;
  logic               l_fault, l_hit;

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign req_off = req_vaddr_i[OFF_W-1:0];

  tlb_cam  #(.N(NUM_ENT)) u_look_cam (.ent_i(ent_q), .vpn_i(req_vpn), .pid_i(req_pid_i), .match_o(l_match));
  tlb_prio #(.N(NUM_ENT), .IDX_W(IDX_W)) u_look_sel (.vec_i(l_match), .any_o(l_any), .idx_o(l_idx));

  assign l_ent   = ent_q[l_idx];
  assign l_fault = req_valid_i && l_any && req_store_i && l_ent.wp;
  assign l_hit   = req_valid_i && l_any && !l_fault;

  // refill path
  logic [NUM_ENT-1:0] f_match;
  logic [IDX_W-1:0]   f_idx;
  logic               f_use_rr;

  tlb_cam    #(.N(NUM_ENT)) u_fill_cam (.ent_i(ent_q), .vpn_i(fill_vpn_i), .pid_i(fill_pid_i), .match_o(f_match));
  tlb_victim #(.N(NUM_ENT), .IDX_W(IDX_W)) u_victim (
    .match_i (f_match),
    .valid_i (valid_vec),
    .rr_i    (rr_q),
    .idx_o   (f_idx),
    .use_rr_o(f_use_rr)
  );

  // next state: dirty update < refill < flush
  always_comb begin
    ent_d = ent_q;
    rr_d  = rr_q;
    if (l_hit && req_store_i) ent_d[l_idx].dirty = 1'b1;
    if (fill_valid_i) begin
      ent_d[f_idx].valid = 1'b1;
      ent_d[f_idx].vpn   = fill_vpn_i;
      ent_d[f_idx].pid   = fill_pid_i;
      ent_d[f_idx].pfn   = fill_pfn_i;
      ent_d[f_idx].wp    = fill_wp_i;
      ent_d[f_idx].dirty = fill_dirty_i;
      if (f_use_rr) rr_d = (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
    if (flush_i) begin
      for (int i = 0; i < NUM_ENT; i++) ent_d[i].valid = 1'b0;
      rr_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      rr_q  <= '0;
    end else begin
      ent_q <= ent_d;
      rr_q  <= rr_d;
    end
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_dirty_o <= 1'b0;
      rsp_wp_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= l_hit;
      rsp_miss_o  <= req_valid_i && !l_any;
      rsp_fault_o <= l_fault;
      rsp_paddr_o <= l_hit ? {l_ent.pfn, req_off} : '0;
      rsp_dirty_o <= (req_valid_i && l_any) ? (l_ent.dirty || l_hit && req_store_i) : 1'b0;
      rsp_wp_o    <= (req_valid_i && l_any) ? l_ent.wp : 1'b0;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int N = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_valid_i,
  input logic                      req_store_i,
  input logic [tlb_pkg::VA_W-1:0]  req_vaddr_i,
  input logic                      flush_i,
  input logic                      rsp_valid_o,
  input logic                      rsp_hit_o,
  input logic                      rsp_miss_o,
  input logic                      rsp_fault_o,
  input logic [tlb_pkg::PA_W-1:0]  rsp_paddr_o,
  input logic                      rsp_dirty_o,
  input logic                      rsp_wp_o,
  input logic [N-1:0]              valid_vec
);
  localparam int OW = tlb_pkg::OFF_W;

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_fault_o)); // R4
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1)); // R4
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_hit_o -> (rsp_paddr_o[OW-1:0] == $past(req_vaddr_i[OW-1:0])))); // R1
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (rsp_paddr_o == '0 && !rsp_dirty_o && !rsp_wp_o)); // R3
  AST_FAULT_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |=> !rsp_fault_o); // R5
  AST_FAULT_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_wp_o && rsp_paddr_o == '0)); // R5
  AST_STORE_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i) |=> (rsp_hit_o -> rsp_dirty_o)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_vec == '0)); // R9
endmodule

bind tagged_xlate_cache tlb_chk #(.N(NUM_ENT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_store_i(req_store_i),
  .req_vaddr_i(req_vaddr_i),
  .flush_i    (flush_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_miss_o (rsp_miss_o),
  .rsp_fault_o(rsp_fault_o),
  .rsp_paddr_o(rsp_paddr_o),
  .rsp_dirty_o(rsp_dirty_o),
  .rsp_wp_o   (rsp_wp_o),
  .valid_vec  (valid_vec)
);

// File: tb/sim_tagged_xlate_cache.sv
module sim_tagged_xlate_cache;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 0, req_store_i = 0, flush_i = 0;
  logic [15:0] req_vaddr_i = '0;
  logic [3:0]  req_pid_i = '0;
  logic        fill_valid_i = 0, fill_wp_i = 0, fill_dirty_i = 0;
  logic [5:0]  fill_vpn_i = '0;
  logic [3:0]  fill_pid_i = '0;
  logic [7:0]  fill_pfn_i = '0;
  logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_dirty_o, rsp_wp_o;
  logic [17:0] rsp_paddr_o;

  always #2.5 clk = ~clk;

  tagged_xlate_cache u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_pid_i(req_pid_i),
    .req_store_i(req_store_i), .flush_i(flush_i),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pid_i(fill_pid_i),
    .fill_pfn_i(fill_pfn_i), .fill_wp_i(fill_wp_i), .fill_dirty_i(fill_dirty_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
    .rsp_fault_o(rsp_fault_o), .rsp_paddr_o(rsp_paddr_o),
    .rsp_dirty_o(rsp_dirty_o), .rsp_wp_o(rsp_wp_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  bit       m_v[N];
  bit [5:0] m_vpn[N];
  bit [3:0] m_pid[N];
  bit [7:0] m_pfn[N];
  bit       m_wp[N];
  bit       m_d[N];
  int       m_rr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int find(input bit [5:0] vpn, input bit [3:0] pid);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  function automatic int fill_slot(input bit [5:0] vpn, input bit [3:0] pid);
    int k = find(vpn, pid);
    if (k >= 0) return k;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  function automatic void clear_model();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
  endfunction

  // one cycle: optional lookup, refill, flush; response checked when do_req
  task automatic op(input bit do_req, input bit [5:0] vpn, input bit [3:0] pid,
                    input bit [9:0] off, input bit st,
                    input bit do_fill, input bit [5:0] fvpn, input bit [3:0] fpid,
                    input bit [7:0] fpfn, input bit fwp, input bit fd,
                    input bit do_flush, input string req);
    int  k, s;
    bit  e_hit, e_miss, e_fault, e_d, e_wp;
    bit [17:0] e_pa;
    k = find(vpn, pid);
    e_miss  = (k < 0);
    e_fault = (k >= 0) && st && m_wp[k];
    e_hit   = (k >= 0) && !e_fault;
    e_pa    = e_hit ? {m_pfn[k], off} : 18'h0;
    e_wp    = (k >= 0) ? m_wp[k] : 1'b0;
    e_d     = (k >= 0) ? (m_d[k] | (e_hit & st)) : 1'b0;
    if (do_req && e_hit && st) m_d[k] = 1;
    if (do_fill) begin
      s = fill_slot(fvpn, fpid);
      if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % N; end
      m_v[s] = 1; m_vpn[s] = fvpn; m_pid[s] = fpid; m_pfn[s] = fpfn; m_wp[s] = fwp; m_d[s] = fd;
    end
    if (do_flush) clear_model();

    req_valid_i = do_req; req_vaddr_i = {vpn, off}; req_pid_i = pid; req_store_i = st;
    fill_valid_i = do_fill; fill_vpn_i = fvpn; fill_pid_i = fpid; fill_pfn_i = fpfn;
    fill_wp_i = fwp; fill_dirty_i = fd; flush_i = do_flush;
    @(posedge clk); @(negedge clk);
    req_valid_i = 0; fill_valid_i = 0; flush_i = 0;
    check(rsp_valid_o == do_req, req, "valid", rsp_valid_o, do_req);
    if (do_req) begin
      check(rsp_hit_o == e_hit, req, "hit", rsp_hit_o, e_hit);
      check(rsp_miss_o == e_miss, req, "miss", rsp_miss_o, e_miss);
      check(rsp_fault_o == e_fault, req, "fault", rsp_fault_o, e_fault);
      check(rsp_paddr_o == e_pa, req, "paddr", rsp_paddr_o, e_pa);
      check(rsp_dirty_o == e_d, req, "dirty", rsp_dirty_o, e_d);
      check(rsp_wp_o == e_wp, req, "wp", rsp_wp_o, e_wp);
    end
  endtask

  task automatic look(input bit [5:0] vpn, input bit [3:0] pid, input bit [9:0] off,
                      input bit st, input string req);
    op(1, vpn, pid, off, st, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic fill(input bit [5:0] vpn, input bit [3:0] pid, input bit [7:0] pfn,
                      input bit wp, input string req);
    op(0, 0, 0, 0, 0, 1, vpn, pid, pfn, wp, 0, 0, req);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_model();
    repeat (3) @(negedge clk);
    // R4 reset state
    check(!rsp_valid_o && !rsp_hit_o && !rsp_miss_o && !rsp_fault_o && rsp_paddr_o == 0,
          "R4", "reset outputs", {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    look(6'd5, 4'd1, 10'h155, 0, "R3");           // empty cache
    fill(6'd5, 4'd1, 8'hA3, 0, "R7");
    look(6'd5, 4'd1, 10'h155, 0, "R1");           // {A3,155}
    look(6'd5, 4'd2, 10'h155, 0, "R2");           // pid mismatch -> miss
    fill(6'd5, 4'd2, 8'h11, 0, "R7");             // new slot 1
    look(6'd5, 4'd2, 10'h3FF, 0, "R2");
    fill(6'd5, 4'd1, 8'h22, 0, "R7");             // in place on slot 0
    look(6'd5, 4'd1, 10'h000, 0, "R7");
    fill(6'd9, 4'd1, 8'h40, 1, "R5");
    look(6'd9, 4'd1, 10'h010, 0, "R5");           // load to protected -> hit
    look(6'd9, 4'd1, 10'h010, 1, "R5");           // store -> fault
    look(6'd9, 4'd1, 10'h010, 0, "R5");           // dirty stays 0
    look(6'd5, 4'd1, 10'h001, 1, "R6");           // store sets dirty
    look(6'd5, 4'd1, 10'h002, 0, "R6");
    // R9 flush with same-cycle lookup sees old contents; same-cycle fill discarded
    op(1, 6'd5, 4'd1, 10'h7, 0, 1, 6'd20, 4'd3, 8'h77, 0, 0, 1, "R9");
    look(6'd5, 4'd1, 10'h7, 0, "R9");
    look(6'd20, 4'd3, 10'h7, 0, "R9");
    // R8 fill all 8, then two evictions in round-robin order
    for (int i = 0; i < N; i++) fill(6'(i + 30), 4'd4, 8'(i + 1), 0, "R8");
    fill(6'd50, 4'd4, 8'hE0, 0, "R8");
    look(6'd30, 4'd4, 10'h1, 0, "R8");
    look(6'd31, 4'd4, 10'h1, 0, "R8");
    fill(6'd51, 4'd4, 8'hE1, 0, "R8");
    look(6'd31, 4'd4, 10'h1, 0, "R8");
    look(6'd50, 4'd4, 10'h2, 0, "R8");
    // R10 lookup and refill of the same page in one cycle
    op(1, 6'd60, 4'd6, 10'h5, 0, 1, 6'd60, 4'd6, 8'h66, 0, 0, 0, "R10");
    look(6'd60, 4'd6, 10'h5, 0, "R10");
    // R10 store hit and refill to the same entry: refill's dirty wins
    op(1, 6'd60, 4'd6, 10'h5, 1, 1, 6'd60, 4'd6, 8'h67, 0, 0, 0, "R10");
    look(6'd60, 4'd6, 10'h5, 0, "R10");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit dr, df, dfl, st, wp, fd;
      bit [5:0] v, fv;
      bit [3:0] p, fp;
      dr  = ($urandom % 4) != 0;
      df  = ($urandom % 3) == 0;
      dfl = ($urandom % 97) == 0;
      v = 6'($urandom % 12); p = 4'($urandom % 3);
      fv = 6'($urandom % 12); fp = 4'($urandom % 3);
      st = $urandom % 2; wp = ($urandom % 4) == 0; fd = ($urandom % 5) == 0;
      op(dr, v, p, 10'($urandom), st, df, fv, fp, 8'($urandom), wp, fd, dfl, "R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule